// File: doc/BRIEF.md
# Multi-level trigger sequencer

This block decides, sample by sample, when a logic capture engine has found the event it is looking for and which samples it should keep on the way there. Each sampled word is compared against ten masked pattern recognizers and two inclusive range recognizers. Two timers count clock cycles. Every one of these results, plus a constant true and a constant false source, can feed the qualifier terms of the sequencer.

The sequencer walks through up to twelve levels. Each level has four parts. The first is an advance term with an occurrence count. The second is a branch term with a target level. The third is a storage term that drives the per-sample store enable. The fourth is a set of timer actions that are applied when the level is entered. When the sequence completes it emits a one-cycle trigger pulse. After the pulse the block stays idle until it is armed again. A timing-mode input limits the usable depth to ten levels.

Software loads all settings through a single-cycle register write port before it pulses `arm`.

Top module: `trig_seq`

## Requirements
- R1: Pattern recognizer p (0 to 9) is written at address 2p for the compare value and at address 2p+1 for the care mask (a mask bit of 1 means the bit is compared). It is true when `((data ^ value) & mask) == 0`. It is qualifier source p.
- R2: Range recognizer r (0 to 1) has its low bound at address 32+2r and its high bound at address 33+2r. It is true when low <= data <= high, compared unsigned with both bounds included. It is qualifier source 10+r.
- R3: A qualifier term is 11 bits wide. Bits [3:0] hold source A, bits [7:4] hold source B and bits [10:8] hold the operator. The operator codes are: 0 A, 1 NOT A, 2 AND, 3 NAND, 4 OR, 5 NOR, 6 XOR, 7 XNOR. Source 14 is always true and source 15 is never true.
- R4: Level l uses the words at 64+4l and 64+4l+1. The first word holds the advance term and the second holds the occurrence count N. The sequencer moves to level l+1 on the N-th valid sample that meets the advance term, where a count of 0 acts as 1. The count reloads every time a level is entered, including a branch back to the same level.
- R5: The word at 64+4l+2 holds the branch term in bits [10:0] and the target level in bits [19:16]. A valid sample that meets the branch term jumps to the target. The branch wins over the advance path when both are true.
- R6: The word at 64+4l+3 holds the storage term in bits [10:0]. `store_en` equals that term of the active level during a valid sample while the block is busy, in the same cycle. Otherwise `store_en` is 0.
- R7: Timer t (0 to 1) is qualifier source 12+t. Its limit is at address 40+t. The timer is true while its count is at or above the limit. The count advances by one each clock while the timer runs and saturates at its maximum.
- R8: The timer actions in bits [17:16] (timer 0) and [19:18] (timer 1) of word 64+4l+3 apply on entry to level l. The codes are: 1 clear and run, 2 stop and hold, 3 resume. Actions are ignored on entry to level 0.
- R9: Address 48 holds the last level. Leaving the last level by advance, or branching to any level above it, raises `trig` for exactly one cycle on the following clock and clears `busy`. After that, `level` holds and `trig` and `store_en` stay low until `arm`.
- R10: When `tmode` is 1 the last level is capped at 9. When `tmode` is 0 it is capped at 11.
- R11: `arm` restarts the sequencer at level 0 with `busy` high and both timers cleared and stopped. A sample presented in the same cycle as `arm` is ignored.
- R12: After reset `trig`, `store_en` and `busy` are 0 and `level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| tmode | input | 1 | 1 limits the sequence to ten levels |
| arm | input | 1 | Restart the sequencer at level 0 |
| smp_valid | input | 1 | A sampled word is present |
| smp_data | input | 32 | Sampled word |
| store_en | output | 1 | Keep this sample |
| trig | output | 1 | One-cycle pulse when the sequence completes |
| busy | output | 1 | Sequencer is running |
| level | output | 4 | Active level |

## Verification
A wrong occurrence counter or a count that fails to reload moves the trigger pulse earlier or later by whole samples. The bench sees this at the exact cycle it checks `trig`. A wrong active level shows up in `level` one clock after the transition, and it also shows up in the same cycle as a `store_en` that follows the wrong storage term. A timer that is cleared, held or resumed wrongly moves the pulse by a predictable number of cycles. The bench derives those cycles from the limit and from the clock edges at which each level is entered. A stuck `busy` shows up as extra pulses or as a `level` that keeps changing after completion.

// File: rtl/trig_seq.sv
`timescale 1ns/1ps
module trig_seq #(
  parameter int DW = 32,
  parameter int NPAT = 10,
  parameter int NRNG = 2,
  parameter int NTMR = 2,
  parameter int NLVL = 12,
  parameter int NLVL_TIM = 10,
  parameter int CW = 20,
  parameter int TW = 32,
  parameter int AW = 8,
  parameter int CFGW = 32,
  localparam int LW = $clog2(NLVL + 1)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [CFGW-1:0] cfg_wdata,
  input  logic            tmode,
  input  logic            arm,
  input  logic            smp_valid,
  input  logic [DW-1:0]   smp_data,
  output logic            store_en,
  output logic            trig,
  output logic            busy,
  output logic [LW-1:0]   level
);
  localparam int NSRC = NPAT + NRNG + NTMR + 2;
  localparam int SW = $clog2(NSRC);
  localparam int TRW = 3 + 2 * SW;
  localparam int HI_LSB = 16;
  localparam int A_RNG = 32;
  localparam int A_TLIM = 40;
  localparam int A_LAST = 48;
  localparam int A_LVL = 64;

  logic [DW-1:0]     pat_val [NPAT];
  logic [DW-1:0]     pat_msk [NPAT];
  logic [DW-1:0]     rng_lo [NRNG];
  logic [DW-1:0]     rng_hi [NRNG];
  logic [TW-1:0]     tlim [NTMR];
  logic [TRW-1:0]    lv_adv [NLVL];
  logic [TRW-1:0]    lv_br [NLVL];
  logic [TRW-1:0]    lv_st [NLVL];
  logic [CW-1:0]     lv_cnt [NLVL];
  logic [LW-1:0]     lv_tgt [NLVL];
  logic [2*NTMR-1:0] lv_act [NLVL];
  logic [LW-1:0]     last_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPAT; p++) begin pat_val[p] <= '0; pat_msk[p] <= '0; end
      for (int r = 0; r < NRNG; r++) begin rng_lo[r] <= '0; rng_hi[r] <= '0; end
      for (int t = 0; t < NTMR; t++) tlim[t] <= '0;
      for (int l = 0; l < NLVL; l++) begin
        lv_adv[l] <= '1; lv_br[l] <= '1; lv_st[l] <= '1;
        lv_cnt[l] <= '0; lv_tgt[l] <= '0; lv_act[l] <= '0;
      end
      last_cfg <= '0;
    end else if (cfg_we) begin
      for (int p = 0; p < NPAT; p++) begin
        if (cfg_addr == AW'(2 * p))     pat_val[p] <= cfg_wdata[DW-1:0];
        if (cfg_addr == AW'(2 * p + 1)) pat_msk[p] <= cfg_wdata[DW-1:0];
      end
      for (int r = 0; r < NRNG; r++) begin
        if (cfg_addr == AW'(A_RNG + 2 * r))     rng_lo[r] <= cfg_wdata[DW-1:0];
        if (cfg_addr == AW'(A_RNG + 2 * r + 1)) rng_hi[r] <= cfg_wdata[DW-1:0];
      end
      for (int t = 0; t < NTMR; t++)
        if (cfg_addr == AW'(A_TLIM + t)) tlim[t] <= cfg_wdata[TW-1:0];
      if (cfg_addr == AW'(A_LAST)) last_cfg <= cfg_wdata[LW-1:0];
      for (int l = 0; l < NLVL; l++) begin
        if (cfg_addr == AW'(A_LVL + 4 * l))     lv_adv[l] <= cfg_wdata[TRW-1:0];
        if (cfg_addr == AW'(A_LVL + 4 * l + 1)) lv_cnt[l] <= cfg_wdata[CW-1:0];
        if (cfg_addr == AW'(A_LVL + 4 * l + 2)) begin
          lv_br[l]  <= cfg_wdata[TRW-1:0];
          lv_tgt[l] <= cfg_wdata[HI_LSB +: LW];
        end
        if (cfg_addr == AW'(A_LVL + 4 * l + 3)) begin
          lv_st[l]  <= cfg_wdata[TRW-1:0];
          lv_act[l] <= cfg_wdata[HI_LSB +: 2*NTMR];
        end
      end
    end
  end

  logic [NSRC-1:0] src;

  for (genvar p = 0; p < NPAT; p++) begin : g_pat
    assign src[p] = ((smp_data ^ pat_val[p]) & pat_msk[p]) == '0;
  end
  for (genvar r = 0; r < NRNG; r++) begin : g_rng
    assign src[NPAT + r] = (smp_data >= rng_lo[r]) && (smp_data <= rng_hi[r]);
  end
  assign src[NSRC-2] = 1'b1;
  assign src[NSRC-1] = 1'b0;

  function automatic logic term_hit(input logic [TRW-1:0] tm, input logic [NSRC-1:0] s);
    logic a, b;
    a = s[tm[SW-1:0]];
    b = s[tm[2*SW-1:SW]];
    case (tm[TRW-1 -: 3])
      3'd0: return a;
      3'd1: return !a;
      3'd2: return a & b;
      3'd3: return !(a & b);
      3'd4: return a | b;
      3'd5: return !(a | b);
      3'd6: return a ^ b;
      default: return !(a ^ b);
    endcase
  endfunction

  logic          running, adv_hit, br_hit, st_hit, go, fire, step_cnt;
  logic [LW-1:0] lvl, nxt, cap, eff_last;
  logic [CW-1:0] occ;

  assign adv_hit  = term_hit(lv_adv[lvl], src);
  assign br_hit   = term_hit(lv_br[lvl], src);
  assign st_hit   = term_hit(lv_st[lvl], src);
  assign cap      = tmode ? LW'(NLVL_TIM - 1) : LW'(NLVL - 1);
  assign eff_last = (last_cfg > cap) ? cap : last_cfg;
  assign go       = running && smp_valid && !arm && (br_hit || (adv_hit && occ <= CW'(1)));
  assign nxt      = br_hit ? lv_tgt[lvl] : lvl + LW'(1);
  assign fire     = go && (nxt > eff_last);
  assign step_cnt = running && smp_valid && adv_hit && !br_hit && (occ > CW'(1));
  assign store_en = running && smp_valid && !arm && st_hit;
  assign busy     = running;
  assign level    = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      lvl     <= '0;
      occ     <= '0;
      trig    <= 1'b0;
    end else begin
      trig <= fire;
      if (arm) begin
        running <= 1'b1;
        lvl     <= '0;
        occ     <= lv_cnt[0];
      end else if (go) begin
        if (fire) running <= 1'b0;
        else begin
          lvl <= nxt;
          occ <= lv_cnt[nxt];
        end
      end else if (step_cnt) begin
        occ <= occ - CW'(1);
      end
    end
  end

  for (genvar t = 0; t < NTMR; t++) begin : g_tmr
    logic [TW-1:0] cnt;
    logic          run;
    logic [1:0]    act;
    assign act = (go && !fire && nxt != '0) ? lv_act[nxt][2*t +: 2] : 2'd0;
    assign src[NPAT + NRNG + t] = cnt >= tlim[t];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
        run <= 1'b0;
      end else if (arm) begin
        cnt <= '0;
        run <= 1'b0;
      end else begin
        case (act)
          2'd1: begin cnt <= '0; run <= 1'b1; end
          2'd2: run <= 1'b0;
          2'd3: begin
            run <= 1'b1;
            if (run && cnt != '1) cnt <= cnt + TW'(1);
          end
          default: if (run && cnt != '1) cnt <= cnt + TW'(1);
        endcase
      end
    end
  end
endmodule

// File: rtl/trig_seq_chk.sv
`timescale 1ns/1ps
module trig_seq_chk #(
  parameter int LW = 4
)(
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic          trig,
  input logic          store_en,
  input logic          busy,
  input logic [LW-1:0] level
);
  // R9
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) trig |=> !trig);
  // R9
  trig_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) trig |-> !busy);
  // R6
  store_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) store_en |-> busy);
  // R11
  arm_start_chk: assert property (@(posedge clk) disable iff (!rst_n) arm |=> (busy && level == '0));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !arm) |=> (!busy && $stable(level)));
endmodule

bind trig_seq trig_seq_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig),
  .store_en(store_en), .busy(busy), .level(level)
);

// File: tb/tb_trig_seq.sv
`timescale 1ns/1ps
module tb_trig_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        tmode = 1'b0;
  logic        arm = 1'b0;
  logic        smp_valid = 1'b0;
  logic [31:0] smp_data = '0;
  logic        store_en, trig, busy;
  logic [3:0]  level;
  logic        st_s;
  int n_chk = 0;
  int n_fail = 0;

  localparam int ANY = 14;
  localparam int NEVER = 15;

  always #2.5 clk = ~clk;

  trig_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .tmode(tmode), .arm(arm), .smp_valid(smp_valid), .smp_data(smp_data),
    .store_en(store_en), .trig(trig), .busy(busy), .level(level)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] tm(input int op, input int a, input int b);
    return 32'((op << 8) | (b << 4) | a);
  endfunction

  task automatic wr(input int addr, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = 8'(addr); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic set_lvl(input int l, input logic [31:0] adv, input int cnt, input logic [31:0] br,
                         input int tgt, input logic [31:0] st, input int act);
    wr(64 + 4*l, adv);
    wr(65 + 4*l, 32'(cnt));
    wr(66 + 4*l, br | 32'(tgt << 16));
    wr(67 + 4*l, st | 32'(act << 16));
  endtask

  task automatic clr_cfg();
    for (int l = 0; l < 12; l++)
      set_lvl(l, tm(0, NEVER, 0), 1, tm(0, NEVER, 0), 0, tm(0, NEVER, 0), 0);
    wr(48, 0);
    tmode = 1'b0;
  endtask

  task automatic do_arm();
    arm = 1'b1;
    @(posedge clk); #1;
    arm = 1'b0;
  endtask

  task automatic cyc(input logic v, input logic [31:0] d);
    smp_valid = v; smp_data = d;
    #1 st_s = store_en;
    @(posedge clk); #1;
    smp_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got %0h expected %0h", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R12 reset state
    chk(!trig && !busy && !store_en && level == 0, "R12 reset", {trig, busy, store_en, level}, 0);

    // R1 pattern recognizers, every index, sweep low nibble with masked noise
    clr_cfg();
    wr(48, 0);
    for (int p = 0; p < 10; p++) begin
      logic [31:0] pv, pm;
      pv = {16'hA5A5, 12'h0, 4'(p)};
      pm = 32'hFFFF_000F;
      wr(2*p, pv); wr(2*p + 1, pm);
      wr(64, tm(0, p, 0));
      for (int d = 0; d < 16; d++) begin
        logic [31:0] dd;
        logic ex;
        dd = {16'hA5A5, 12'(d * 37), 4'(d)};
        if (d == 15) dd[31] = 1'b0;
        ex = ((dd ^ pv) & pm) == 0;
        do_arm();
        cyc(1'b1, dd);
        chk(trig == ex, "R1 pattern", trig, ex);
      end
    end

    // R2 range recognizers, sweep across both bounds
    for (int r = 0; r < 2; r++) begin
      int lo, hi;
      lo = 100 + 10*r; hi = 120 + 10*r;
      wr(32 + 2*r, lo); wr(33 + 2*r, hi);
      wr(64, tm(0, 10 + r, 0));
      for (int d = 90; d <= 140; d++) begin
        logic ex;
        ex = (d >= lo) && (d <= hi);
        do_arm();
        cyc(1'b1, 32'(d));
        chk(trig == ex, "R2 range", trig, ex);
      end
    end

    // R3 operators over all input combinations
    wr(0, 1); wr(1, 1); wr(2, 2); wr(3, 2); wr(4, 4); wr(5, 4);
    for (int op = 0; op < 8; op++) begin
      for (int d = 0; d < 4; d++) begin
        logic a, b, ex;
        a = d[0]; b = d[1];
        case (op)
          0: ex = a; 1: ex = !a; 2: ex = a & b; 3: ex = !(a & b);
          4: ex = a | b; 5: ex = !(a | b); 6: ex = a ^ b; default: ex = !(a ^ b);
        endcase
        wr(64, tm(op, 0, 1));
        do_arm();
        cyc(1'b1, 32'(d));
        chk(trig == ex, "R3 operator", trig, ex);
      end
    end
    wr(64, tm(0, ANY, 0)); do_arm(); cyc(1'b1, 0);
    chk(trig == 1'b1, "R3 any source", trig, 1);
    wr(64, tm(0, NEVER, 0)); do_arm(); cyc(1'b1, 0);
    chk(trig == 1'b0, "R3 never source", trig, 0);

    // R4 occurrence counts, hits interleaved with misses
    for (int n = 0; n < 7; n++) begin
      int m, hits;
      bit fired;
      m = (n == 0) ? 1 : n;
      hits = 0; fired = 0;
      wr(64, tm(0, 0, 0)); wr(65, n);
      do_arm();
      for (int k = 0; k < 2*m + 2; k++) begin
        logic [31:0] dd;
        logic ex;
        dd = (k % 2 == 0) ? 32'd1 : 32'd0;
        ex = (dd == 1) && !fired && (hits == m - 1);
        if (dd == 1 && !fired) hits++;
        if (ex) fired = 1;
        cyc(1'b1, dd);
        chk(trig == ex, "R4 occurrence", trig, ex);
      end
    end

    // R4 reload on re-entry via self branch (R5 path)
    clr_cfg();
    wr(0, 1); wr(1, 1); wr(2, 2); wr(3, 2);
    set_lvl(0, tm(0, ANY, 0), 1, tm(0, NEVER, 0), 0, tm(0, NEVER, 0), 0);
    set_lvl(1, tm(0, 0, 0), 2, tm(0, 1, 0), 1, tm(0, NEVER, 0), 0);
    wr(48, 1);
    do_arm();
    begin
      logic [31:0] seq [5] = '{32'd0, 32'd1, 32'd2, 32'd1, 32'd1};
      for (int k = 0; k < 5; k++) begin
        cyc(1'b1, seq[k]);
        chk(trig == (k == 4), "R4 reload", trig, (k == 4));
      end
    end

    // R5 branch priority and branch beyond last level
    clr_cfg();
    set_lvl(0, tm(0, 0, 0), 1, tm(0, 1, 0), 2, tm(0, NEVER, 0), 0);
    wr(48, 2);
    do_arm();
    cyc(1'b1, 3);
    chk(level == 2 && !trig && busy, "R5 branch priority", level, 2);
    wr(66, tm(0, 1, 0) | 32'(5 << 16));
    do_arm();
    cyc(1'b1, 2);
    chk(trig == 1'b1, "R5 branch beyond last", trig, 1);

    // R6 storage qualifier per level
    clr_cfg();
    set_lvl(0, tm(0, NEVER, 0), 1, tm(0, 2, 0), 1, tm(0, 0, 0), 0);
    set_lvl(1, tm(0, NEVER, 0), 1, tm(0, NEVER, 0), 0, tm(0, 1, 0), 0);
    wr(48, 3);
    do_arm();
    for (int d = 0; d < 4; d++) begin
      cyc(1'b1, 32'(d));
      chk(st_s == d[0], "R6 store level0", st_s, d[0]);
    end
    cyc(1'b1, 4);
    chk(st_s == 1'b0 && level == 1, "R6 store level change", {st_s, level}, 1);
    for (int d = 0; d < 4; d++) begin
      cyc(1'b1, 32'(d));
      chk(st_s == d[1], "R6 store level1", st_s, d[1]);
    end
    cyc(1'b0, 3);
    chk(st_s == 1'b0, "R6 store needs valid", st_s, 0);

    // R7 timer limits for both timers; start on entry to level 1 (R8)
    for (int t = 0; t < 2; t++) begin
      for (int lim = 0; lim < 5; lim++) begin
        clr_cfg();
        wr(40 + t, lim);
        set_lvl(0, tm(0, ANY, 0), 1, tm(0, NEVER, 0), 0, tm(0, NEVER, 0), 0);
        set_lvl(1, tm(0, 12 + t, 0), 1, tm(0, NEVER, 0), 0, tm(0, NEVER, 0), 1 << (2*t));
        wr(48, 1);
        do_arm();
        for (int k = 1; k <= lim + 2; k++) begin
          cyc(1'b1, 0);
          chk(trig == (k == lim + 2), "R7 timer limit", trig, (k == lim + 2));
        end
      end
    end

    // R8 actions ignored on level 0
    clr_cfg();
    wr(40, 3);
    set_lvl(0, tm(0, 12, 0), 1, tm(0, NEVER, 0), 0, tm(0, NEVER, 0), 1);
    do_arm();
    begin
      bit seen;
      seen = 0;
      for (int k = 0; k < 10; k++) begin
        cyc(1'b1, 0);
        if (trig) seen = 1;
      end
      chk(!seen && level == 0 && busy, "R8 level0 actions ignored", seen, 0);
    end

    // R8 clear/stop/resume: trigger expected on edge 11 after arm
    clr_cfg();
    wr(40, 4);
    set_lvl(0, tm(0, ANY, 0), 1, tm(0, NEVER, 0), 0, tm(0, ANY, 0), 0);
    set_lvl(1, tm(0, ANY, 0), 3, tm(0, NEVER, 0), 0, tm(0, ANY, 0), 1);
    set_lvl(2, tm(0, ANY, 0), 4, tm(0, NEVER, 0), 0, tm(0, ANY, 0), 2);
    set_lvl(3, tm(0, 12, 0), 1, tm(0, NEVER, 0), 0, tm(0, ANY, 0), 3);
    wr(48, 3);
    do_arm();
    for (int k = 1; k <= 12; k++) begin
      cyc(1'b1, 0);
      if (k <= 11) chk(trig == (k == 11), "R8 pause resume", trig, (k == 11));
      else chk(trig == 1'b0, "R9 single pulse", trig, 0);
    end

    // R9 hold after completion until arm
    begin
      logic [3:0] lv;
      lv = level;
      for (int k = 0; k < 4; k++) begin
        cyc(1'b1, 0);
        chk(!trig && !busy && !st_s && level == lv, "R9 hold", {trig, busy, st_s, level}, lv);
      end
    end

    // R10 depth cap in each mode
    clr_cfg();
    for (int l = 0; l < 12; l++)
      set_lvl(l, tm(0, ANY, 0), 1, tm(0, NEVER, 0), 0, tm(0, NEVER, 0), 0);
    wr(48, 11);
    for (int md = 0; md < 2; md++) begin
      int n;
      tmode = md[0];
      n = md ? 10 : 12;
      do_arm();
      for (int k = 1; k <= n; k++) begin
        cyc(1'b1, 0);
        if (k == n - 1) chk(level == 4'(n - 1), "R10 level before end", level, n - 1);
        chk(trig == (k == n), "R10 depth cap", trig, (k == n));
      end
    end
    tmode = 1'b0;

    // R11 arm restarts mid-sequence and drops the same-cycle sample
    do_arm();
    for (int k = 0; k < 3; k++) cyc(1'b1, 0);
    chk(level == 3, "R11 progress", level, 3);
    arm = 1'b1; smp_valid = 1'b1; smp_data = 0;
    @(posedge clk); #1;
    arm = 1'b0; smp_valid = 1'b0;
    chk(level == 0 && busy && !trig, "R11 arm priority", level, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule